// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Soft Interrupts

This block collects interrupt requests for a small multiprocessor system and turns them into one priority level per processor. System sources enter a shared pending register. Each source has a fixed priority level equal to its index modulo 16, and a disable mask can hide any of them. The highest level that is still visible goes to exactly one processor, chosen by a target register. Each processor also has its own pending word. Software sets bits in its upper half, and a local event port sets or clears single level bits in its lower half.

Each processor slot combines its own pending word with the routed global level. It drives that level and a wake strobe whenever the level is non-zero. When the slot is idle, it latches an interrupt index (type code plus level) that stays until the processor acknowledges it. Slots with no processor fitted stay silent. A simple write-only register bus carries the soft-interrupt, clear, disable-mask and target writes.

Top module: `mp_irq_hub`

## Requirements
- R1: After reset, every processor's level, request, wake and index outputs are 0, the target register is 0, the disable mask is 0 and all pending state is empty.
- R2: A bus write with `bus_addr`=0 to processor `bus_cpu` ORs only bits 31..17 of `bus_wdata` (mask 0xFFFE0000) into that processor's pending word. Bits 16..0 of the data have no effect on the level outputs.
- R3: A processor's soft level is the highest set pending bit j in 17..31, minus 16 (1..15). Its local level is the highest set pending bit in 1..15. Its level output is the maximum of these two and the routed global level.
- R4: The global level is the maximum of (source index mod 16) over all global pending bits whose disable bit is 0. A bus write with `bus_addr`=2 loads the disable mask from `bus_wdata`.
- R5: The global level reaches only the processor whose index equals the target register. A bus write with `bus_addr`=3 loads the target from `bus_wdata[3:0]`.
- R6: `wake_o` of a processor is 1 whenever its level output is non-zero, including while its index is held.
- R7: On a clock edge where a processor's index is 0, its ack is low and its level is L≠0, the index becomes 0x10|L (type code 1 in bits 7..4). A non-zero index holds until ack, and ack clears it at the next edge. `req_o` is 1 while the index is non-zero.
- R8: A local event (`li_stb`) with level L = `li_src` mod 16 sets (`li_set`=1) or clears pending bit L of processor `li_cpu`. An event with L = 0 is ignored. `li_cpu`=15 sends the event to global pending bit `li_src` instead.
- R9: A processor slot marked absent in `CPU_PRESENT` drives level, request and wake to 0, even when it is the target.
- R10: A bus write with `bus_addr`=1 clears the bits of `bus_wdata` in processor `bus_cpu`'s pending word.
- R11: A rising edge on `src_i[i]` sets global pending bit i, and a falling edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | System interrupt source lines |
| li_stb | input | 1 | Local event strobe |
| li_src | input | SRCW | Local event source index |
| li_set | input | 1 | Local event set (1) or clear (0) |
| li_cpu | input | CPUW | Local event processor; all-ones selects global path |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 soft set, 1 pending clear, 2 disable mask, 3 target |
| bus_cpu | input | CPUW | Processor index for per-processor writes |
| bus_wdata | input | 32 | Write data |
| ack_i | input | NCPU | Per-processor acknowledge |
| lvl_o | output | NCPU*4 | Per-processor current level |
| req_o | output | NCPU | Per-processor index held |
| wake_o | output | NCPU | Per-processor wake |
| idx_o | output | NCPU*8 | Per-processor latched interrupt index |

## Verification
The bench uses the defaults: four slots with slot 2 marked absent and 32 global sources. This lets one run exercise routing to a present target, routing to an absent target, and a local event aimed at an absent slot. With 32 sources, every level from 0 to 15 has two sources that map to it, so mask and maximum checks include ties and the level-0 sources. Index 15 is reserved as the global route, so every local event is either a per-slot write or a global-path write.

// File: rtl/mp_irq_pkg.sv
`timescale 1ns/1ps
package mp_irq_pkg;
    localparam int WORDW     = 32;
    localparam int LVLW      = 4;
    localparam int IDXW      = 8;
    localparam int SOFT_BASE = 17;
    localparam logic [WORDW-1:0] SOFT_MASK = 32'hFFFE_0000;
    localparam logic [3:0] EXT_CODE = 4'h1;

    typedef enum logic [1:0] {
        WR_SOFT_SET = 2'd0,
        WR_PEND_CLR = 2'd1,
        WR_GDIS     = 2'd2,
        WR_TARGET   = 2'd3
    } wr_sel_e;

    function automatic logic [LVLW-1:0] src_level(input int s);
        return LVLW'(s % 16);
    endfunction
endpackage

// File: rtl/mp_irq_gsrc.sv
`timescale 1ns/1ps
module mp_irq_gsrc
    import mp_irq_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int SRCW = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_i,
    input  logic                ev_glob,
    input  logic [SRCW-1:0]     ev_src,
    input  logic                ev_set,
    input  logic                dis_we,
    input  logic [WORDW-1:0]    dis_wdata,
    output logic [LVLW-1:0]     glvl_o
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] dis;
    } gsrc_t;

    gsrc_t r_q, r_d;
    logic [NSRC-1:0] live;
    logic [LVLW-1:0] best;

    always_comb begin
        r_d      = r_q;
        r_d.prev = src_i;
        for (int i = 0; i < NSRC; i++) begin
            if (src_i[i] && !r_q.prev[i]) r_d.pend[i] = 1'b1;
            if (!src_i[i] && r_q.prev[i]) r_d.pend[i] = 1'b0;
        end
        if (ev_glob) r_d.pend[ev_src] = ev_set;
        if (dis_we) r_d.dis = dis_wdata[NSRC-1:0];

        live = r_q.pend & ~r_q.dis;
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (live[i] && (src_level(i) > best)) best = src_level(i);
        end
    end

    assign glvl_o = best;

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_ALL_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (&r_q.dis) |-> (glvl_o == '0)); // R4
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[1] && !r_q.prev[1] && !ev_glob) |=> r_q.pend[1]); // R11
endmodule

// File: rtl/mp_irq_slot.sv
`timescale 1ns/1ps
module mp_irq_slot
    import mp_irq_pkg::*;
#(
    parameter int CPU_ID  = 0,
    parameter bit PRESENT = 1'b1,
    parameter int CPUW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_stb,
    input  logic [CPUW-1:0]     ev_cpu,
    input  logic [LVLW-1:0]     ev_lvl,
    input  logic                ev_set,
    input  logic                bus_we,
    input  wr_sel_e             bus_sel,
    input  logic [CPUW-1:0]     bus_cpu,
    input  logic [WORDW-1:0]    bus_wdata,
    input  logic [LVLW-1:0]     glvl_i,
    input  logic [CPUW-1:0]     tgt_i,
    input  logic                ack_i,
    output logic [LVLW-1:0]     lvl_o,
    output logic                req_o,
    output logic                wake_o,
    output logic [IDXW-1:0]     idx_o,
    output logic                ghit_o
);
    typedef struct packed {
        logic [WORDW-1:0] pend;
        logic [IDXW-1:0]  idx;
    } slot_t;

    localparam logic [CPUW-1:0] MY_ID = CPUW'(CPU_ID);

    slot_t r_q, r_d;
    logic [LVLW-1:0] loc_lvl, soft_lvl, cand, lvl_w;
    logic            routed, ev_mine, bus_mine;

    always_comb begin
        loc_lvl  = '0;
        soft_lvl = '0;
        for (int j = 1; j < 16; j++) begin
            if (r_q.pend[j]) loc_lvl = LVLW'(j);
        end
        for (int j = SOFT_BASE; j < WORDW; j++) begin
            if (r_q.pend[j]) soft_lvl = LVLW'(j - 16);
        end
        routed = PRESENT && (tgt_i == MY_ID);
        cand   = routed ? glvl_i : '0;
        lvl_w  = (loc_lvl > soft_lvl) ? loc_lvl : soft_lvl;
        if (cand > lvl_w) lvl_w = cand;
        if (!PRESENT) lvl_w = '0;

        ev_mine  = ev_stb && (ev_cpu == MY_ID) && (ev_lvl != '0);
        bus_mine = bus_we && (bus_cpu == MY_ID);

        r_d = r_q;
        if (ev_mine) r_d.pend[ev_lvl] = ev_set;
        if (bus_mine) begin
            case (bus_sel)
                WR_SOFT_SET: r_d.pend = r_d.pend | (bus_wdata & SOFT_MASK);
                WR_PEND_CLR: r_d.pend = r_d.pend & ~bus_wdata;
                default: ;
            endcase
        end
        if (ack_i)                                r_d.idx = '0;
        else if ((r_q.idx == '0) && (lvl_w != '0)) r_d.idx = {EXT_CODE, lvl_w};
    end

    assign lvl_o  = lvl_w;
    assign wake_o = (lvl_w != '0);
    assign req_o  = PRESENT && (r_q.idx != '0);
    assign idx_o  = PRESENT ? r_q.idx : '0;
    assign ghit_o = routed && (glvl_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (idx_o == '0)); // R7
    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_o != '0) && !ack_i) |=> $stable(idx_o)); // R7
    AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_o == '0) && !ack_i && (lvl_o != '0)) |=> (idx_o == {EXT_CODE, $past(lvl_o)})); // R7
    AST_SOFT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mine && (bus_sel == WR_SOFT_SET) && !ev_mine) |=> (r_q.pend[16:0] == $past(r_q.pend[16:0]))); // R2
endmodule

// File: rtl/mp_irq_hub.sv
`timescale 1ns/1ps
module mp_irq_hub
    import mp_irq_pkg::*;
#(
    parameter int             NCPU        = 4,
    parameter int             NSRC        = 32,
    parameter logic [NCPU-1:0] CPU_PRESENT = 4'b1011,
    localparam int            CPUW        = 4,
    localparam int            SRCW        = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_i,
    input  logic                 li_stb,
    input  logic [SRCW-1:0]      li_src,
    input  logic                 li_set,
    input  logic [CPUW-1:0]      li_cpu,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [CPUW-1:0]      bus_cpu,
    input  logic [WORDW-1:0]     bus_wdata,
    input  logic [NCPU-1:0]      ack_i,
    output logic [NCPU*LVLW-1:0] lvl_o,
    output logic [NCPU-1:0]      req_o,
    output logic [NCPU-1:0]      wake_o,
    output logic [NCPU*IDXW-1:0] idx_o
);
    wr_sel_e         sel;
    logic [CPUW-1:0] tgt_q, tgt_d;
    logic [LVLW-1:0] glvl, ev_lvl;
    logic            ev_glob;
    logic [NCPU-1:0] ghit;

    always_comb begin
        sel     = wr_sel_e'(bus_addr);
        ev_glob = li_stb && (li_cpu == '1);
        ev_lvl  = src_level(int'(li_src));
        tgt_d   = tgt_q;
        if (bus_wr && (sel == WR_TARGET)) tgt_d = bus_wdata[CPUW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    mp_irq_gsrc #(.NSRC(NSRC)) u_gsrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .ev_glob   (ev_glob),
        .ev_src    (li_src),
        .ev_set    (li_set),
        .dis_we    (bus_wr && (sel == WR_GDIS)),
        .dis_wdata (bus_wdata),
        .glvl_o    (glvl)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_slot
        mp_irq_slot #(.CPU_ID(c), .PRESENT(CPU_PRESENT[c]), .CPUW(CPUW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_stb    (li_stb),
            .ev_cpu    (li_cpu),
            .ev_lvl    (ev_lvl),
            .ev_set    (li_set),
            .bus_we    (bus_wr),
            .bus_sel   (sel),
            .bus_cpu   (bus_cpu),
            .bus_wdata (bus_wdata),
            .glvl_i    (glvl),
            .tgt_i     (tgt_q),
            .ack_i     (ack_i[c]),
            .lvl_o     (lvl_o[c*LVLW +: LVLW]),
            .req_o     (req_o[c]),
            .wake_o    (wake_o[c]),
            .idx_o     (idx_o[c*IDXW +: IDXW]),
            .ghit_o    (ghit[c])
        );

        if (!CPU_PRESENT[c]) begin : g_absent
            AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |-> (!wake_o[c] && !req_o[c])); // R9
        end
    end

    AST_ONE_GLOBAL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ghit)); // R5
    AST_WAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o[0] && (lvl_o[LVLW-1:0] != '0)) |-> wake_o[0]); // R6
endmodule

// File: tb/sim_mp_irq_hub.sv
`timescale 1ns/1ps
module sim_mp_irq_hub;
    localparam int NCPU = 4;
    localparam int NSRC = 32;
    localparam logic [NCPU-1:0] PRES = 4'b1011;

    logic clk = 0, rst_n = 0;
    logic [NSRC-1:0] src_i = '0;
    logic li_stb = 0, li_set = 0;
    logic [4:0] li_src = '0;
    logic [3:0] li_cpu = '0, bus_cpu = '0;
    logic bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [NCPU-1:0] ack_i = '0;
    logic [NCPU*4-1:0] lvl_o;
    logic [NCPU-1:0] req_o, wake_o;
    logic [NCPU*8-1:0] idx_o;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [NSRC-1:0] m_prev, m_pend, m_dis;
    logic [3:0]      m_tgt;
    logic [31:0]     m_cp [NCPU];
    logic [7:0]      m_idx [NCPU];

    always #4 clk = ~clk;

    mp_irq_hub u0 (.*);

    function automatic int glvl();
        int b = 0;
        for (int i = 0; i < NSRC; i++)
            if (m_pend[i] && !m_dis[i] && (i % 16) > b) b = i % 16;
        return b;
    endfunction

    function automatic int exp_lvl(int c);
        int b = 0;
        if (!PRES[c]) return 0;
        for (int j = 1; j < 16; j++) if (m_cp[c][j]) b = (j > b) ? j : b;
        for (int j = 17; j < 32; j++) if (m_cp[c][j]) b = (j - 16 > b) ? j - 16 : b;
        if (m_tgt == 4'(c) && glvl() > b) b = glvl();
        return b;
    endfunction

    task automatic chk(bit ok, string tag, int c, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cpu%0d %s actual=%0h expected=%0h", tag, c, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int c = 0; c < NCPU; c++) begin
            int el = exp_lvl(c);
            int ei = PRES[c] ? int'(m_idx[c]) : 0;
            chk(int'(lvl_o[c*4 +: 4]) == el, tag, c, "lvl", int'(lvl_o[c*4 +: 4]), el);
            chk(wake_o[c] == (el != 0), tag, c, "wake", int'(wake_o[c]), int'(el != 0));
            chk(int'(idx_o[c*8 +: 8]) == ei, tag, c, "idx", int'(idx_o[c*8 +: 8]), ei);
            chk(req_o[c] == (ei != 0), tag, c, "req", int'(req_o[c]), int'(ei != 0));
        end
    endtask

    task automatic model_update();
        int lv [NCPU];
        for (int c = 0; c < NCPU; c++) lv[c] = exp_lvl(c);
        for (int i = 0; i < NSRC; i++) begin
            if (src_i[i] && !m_prev[i]) m_pend[i] = 1'b1;
            if (!src_i[i] && m_prev[i]) m_pend[i] = 1'b0;
        end
        m_prev = src_i;
        if (li_stb && li_cpu == 4'hF) m_pend[li_src] = li_set;
        if (bus_wr && bus_addr == 2'd2) m_dis = bus_wdata;
        if (bus_wr && bus_addr == 2'd3) m_tgt = bus_wdata[3:0];
        for (int c = 0; c < NCPU; c++) begin
            if (li_stb && li_cpu == 4'(c) && (li_src % 16) != 0) m_cp[c][li_src % 16] = li_set;
            if (bus_wr && bus_cpu == 4'(c) && bus_addr == 2'd0) m_cp[c] |= bus_wdata & 32'hFFFE0000;
            if (bus_wr && bus_cpu == 4'(c) && bus_addr == 2'd1) m_cp[c] &= ~bus_wdata;
            if (ack_i[c]) m_idx[c] = 8'h00;
            else if (m_idx[c] == 8'h00 && lv[c] != 0) m_idx[c] = {4'h1, 4'(lv[c])};
        end
    endtask

    task automatic advance();
        model_update();
        @(posedge clk);
        @(negedge clk);
        li_stb = 0; bus_wr = 0; ack_i = '0;
    endtask

    task automatic bus(input logic [1:0] a, input logic [3:0] c, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_cpu = c; bus_wdata = d;
        advance();
    endtask

    task automatic lev(input logic [3:0] c, input logic [4:0] s, input logic st);
        li_stb = 1; li_cpu = c; li_src = s; li_set = st;
        advance();
    endtask

    initial begin
        m_prev = '0; m_pend = '0; m_dis = '0; m_tgt = '0;
        for (int c = 0; c < NCPU; c++) begin m_cp[c] = '0; m_idx[c] = '0; end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all("R1");

        bus(2'd0, 4'd0, 32'h0001_FFFF); compare_all("R2");
        bus(2'd0, 4'd0, 32'h0004_0000); compare_all("R3");
        advance(); compare_all("R7");
        bus(2'd0, 4'd0, 32'h8000_0000); compare_all("R6");
        advance(); compare_all("R7");
        ack_i[0] = 1; advance(); compare_all("R7");
        advance(); compare_all("R7");
        bus(2'd1, 4'd0, 32'hFFFF_FFFF); ack_i[0] = 1; advance(); compare_all("R10");

        src_i[5] = 1; advance(); compare_all("R11");
        src_i[20] = 1; advance(); compare_all("R4");
        bus(2'd2, 4'd0, 32'h0000_0020); compare_all("R4");
        src_i[20] = 0; advance(); compare_all("R11");
        bus(2'd2, 4'd0, 32'h0); src_i[7] = 1; advance();
        bus(2'd3, 4'd0, 32'h1); compare_all("R5");
        lev(4'd3, 5'd9, 1'b1); compare_all("R8");
        lev(4'd3, 5'd16, 1'b1); compare_all("R8");
        lev(4'hF, 5'd13, 1'b1); compare_all("R8");
        lev(4'd3, 5'd9, 1'b0); compare_all("R8");
        bus(2'd3, 4'd0, 32'h2); compare_all("R9");
        lev(4'd2, 5'd11, 1'b1); compare_all("R9");
        bus(2'd0, 4'd2, 32'hFFFF_0000); compare_all("R9");
        ack_i = '1; advance(); compare_all("R7");

        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 9);
            if (k < 2) src_i[$urandom_range(0, NSRC-1)] ^= 1'b1;
            if (k == 3 || k == 4) begin
                li_stb = 1; li_src = 5'($urandom_range(0, 31)); li_set = 1'($urandom);
                li_cpu = ($urandom_range(0, 4) == 4) ? 4'hF : 4'($urandom_range(0, 3));
            end
            if (k >= 5 && k <= 7) begin
                bus_wr = 1; bus_addr = 2'($urandom); bus_cpu = 4'($urandom_range(0, 3));
                bus_wdata = $urandom;
                if (bus_addr == 2'd3) bus_wdata = 32'($urandom_range(0, 4));
                if (bus_addr == 2'd1 && $urandom_range(0, 1) == 1) bus_wdata = 32'hFFFF_FFFF;
            end
            ack_i = NCPU'($urandom) & NCPU'($urandom);
            advance();
            compare_all("R3/R4/R5/R7/R8");
        end

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule